// File: doc/BRIEF.md
# Eight-lane double-rate converter word deserializer

This block turns the serial output of an eight-channel sampling converter back into parallel samples. Each channel arrives on its own single-bit lane. A shared frame lane marks where each sample word starts and ends. The lanes are captured on both edges of the converter's bit clock. An input register stage in front of this block already splits each lane into a rise bit and a fall bit per capture-clock cycle. The rise bit is the earlier bit in time. The block therefore consumes two bits per lane on every clock.

The frame lane is kept in a short bit history, just like the data lanes. A word boundary is recognised when the newest N frame bits show N/2 ones followed by N/2 zeros. N is the active word length. The boundary may end on the fall bit or on the rise bit of a cycle. Once two boundaries in a row arrive exactly N/2 cycles apart at the same bit offset, the block declares lock. From then on, at every boundary it captures one word per lane, reformats it and presents all eight together with a single valid pulse.

A run-time control selects 14-bit or 12-bit words. A second control selects output coding. A change of word length discards lock, and the block must align again before it releases any more words.

Top module: `adc_ddr_deser`

## Requirements
- R1: While `rst_n` is low, `valid_o` and `locked_o` are 0 and `samples_o` is all zeros.
- R2: In 14-bit mode (`short_mode_i`=0) with `offset_bin_i`=0, each lane's word is its 14 bits up to the boundary. The oldest bit is the MSB, and the rise bit precedes the fall bit of the same cycle. The word is output unchanged. Lane k (A=0 … H=7) appears at `samples_o[k*14 +: 14]`.
- R3: A boundary is a window of the newest N frame bits, ending at the fall bit (preferred) or at the rise bit. The window must read N/2 ones then N/2 zeros, oldest first. `locked_o` rises once two successive boundaries fall N/2 cycles apart at the same bit offset.
- R4: A boundary that is late, missing, early or at the other bit offset clears lock. After a one-bit slip of the streams, lock returns after two consistent boundaries.
- R5: `valid_o` pulses for one cycle on every boundary seen while locked, on the clock edge after the edge that captured the word's last bit. `samples_o` holds its value between pulses, and `valid_o` is never high without `locked_o`.
- R6: In 12-bit mode (`short_mode_i`=1), words are 12 bits long. Bits 13:12 of each lane copy bit 11 of the coded word.
- R7: With `offset_bin_i`=1, the word's top bit (bit N-1) is inverted before sign extension. With 0, two's complement passes through.
- R8: A change of `short_mode_i` clears lock and suppresses `valid_o` on the next cycle. Alignment restarts under the new word length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, one cycle per bit-clock period |
| rst_n | input | 1 | Asynchronous active-low reset |
| short_mode_i | input | 1 | 1 selects 12-bit words, 0 selects 14-bit words |
| offset_bin_i | input | 1 | 1 selects offset-binary output coding |
| lane_rise_i | input | 8 | Earlier bit of each data lane this cycle |
| lane_fall_i | input | 8 | Later bit of each data lane this cycle |
| frame_rise_i | input | 1 | Earlier bit of the frame lane |
| frame_fall_i | input | 1 | Later bit of the frame lane |
| samples_o | output | 112 | Eight 14-bit samples, lane A in the low bits |
| valid_o | output | 1 | One-cycle pulse per released word set |
| locked_o | output | 1 | Alignment held |

## Verification
A boundary check and a lock-state update can land in the same cycle with conflicting outcomes. After a one-bit slip, the new boundary arrives at the other bit offset in the very cycle where the old offset was expected. The bench provokes this by duplicating one bit-time in all lanes at once, mid-stream. The per-cycle reference model then decides whether that coincident hit restarts the count or keeps it, and so whether the valid pulse must vanish. A word-length change applied while a boundary is due also collides with word release; the model requires the release to be withheld.

// File: rtl/adc_deser_pkg.sv
package adc_deser_pkg;
  localparam int unsigned WORD_LONG  = 14;
  localparam int unsigned WORD_SHORT = 12;
  localparam int unsigned LANE_COUNT = 8;
  localparam int unsigned LOCK_RUN   = 2;

  typedef enum logic {
    CODE_TWOS   = 1'b0,
    CODE_OFFSET = 1'b1
  } code_sel_e;
endpackage

// File: rtl/adc_ddr_shift.sv
module adc_ddr_shift #(
  parameter int unsigned DEPTH = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rise_i,
  input  logic             fall_i,
  output logic [DEPTH-1:0] hist_o
);
  logic [DEPTH-1:0] hist_q, hist_d;

  // two new bits per cycle; newest (fall) lands in bit 0
  always_comb begin
    hist_d = {hist_q[DEPTH-3:0], rise_i, fall_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hist_q <= '0;
    else        hist_q <= hist_d;
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/adc_frame_lock.sv
module adc_frame_lock #(
  parameter int unsigned WLONG  = 14,
  parameter int unsigned WSHORT = 12,
  parameter int unsigned DEPTH  = WLONG + 1,
  parameter int unsigned RUN    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             short_i,
  input  logic [DEPTH-1:0] frm_hist_i,
  output logic             take_o,
  output logic             sel_odd_o,
  output logic             locked_o,
  output logic             short_q_o
);
  localparam int unsigned CNT_W = $clog2(RUN + 1);
  localparam int unsigned GAP_W = $clog2(WLONG) + 1;

  logic             short_q, short_d;
  logic             off_q, off_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [GAP_W-1:0] gap_q, gap_d;

  logic m_even, m_odd, hit, hit_off, chg, ontime;
  int unsigned nbits, half;

  // boundary search on both bit offsets
  always_comb begin
    nbits  = short_q ? WSHORT : WLONG;
    half   = nbits / 2;
    m_even = 1'b1;
    m_odd  = 1'b1;
    for (int unsigned j = 0; j < WLONG; j++) begin
      if (j < nbits) begin
        if (frm_hist_i[j]     != (j >= half)) m_even = 1'b0;
        if (frm_hist_i[j + 1] != (j >= half)) m_odd  = 1'b0;
      end
    end
    hit     = m_even | m_odd;
    hit_off = ~m_even;
  end

  // next-state
  always_comb begin
    chg     = short_i ^ short_q;
    ontime  = (cnt_q != '0) && (gap_q == GAP_W'(half - 1));
    short_d = short_i;
    off_d   = off_q;
    cnt_d   = cnt_q;
    gap_d   = (gap_q == {GAP_W{1'b1}}) ? gap_q : gap_q + 1'b1;
    if (chg) begin
      cnt_d = '0;
      gap_d = '0;
    end else if (hit) begin
      gap_d = '0;
      off_d = hit_off;
      if (ontime && (hit_off == off_q))
        cnt_d = (cnt_q == CNT_W'(RUN)) ? cnt_q : cnt_q + 1'b1;
      else
        cnt_d = CNT_W'(1);
    end else if (ontime) begin
      cnt_d = '0;
    end
    take_o = hit & ~chg & (cnt_d == CNT_W'(RUN));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      short_q <= 1'b0;
      off_q   <= 1'b0;
      cnt_q   <= '0;
      gap_q   <= '0;
    end else begin
      short_q <= short_d;
      off_q   <= off_d;
      cnt_q   <= cnt_d;
      gap_q   <= gap_d;
    end
  end

  assign sel_odd_o = hit_off;
  assign locked_o  = (cnt_q == CNT_W'(RUN));
  assign short_q_o = short_q;
endmodule

// File: rtl/adc_lane_fmt.sv
module adc_lane_fmt #(
  parameter int unsigned WLONG  = 14,
  parameter int unsigned WSHORT = 12,
  parameter int unsigned DEPTH  = WLONG + 1
) (
  input  logic [DEPTH-1:0] hist_i,
  input  logic             sel_odd_i,
  input  logic             short_i,
  input  logic             offs_i,
  output logic [WLONG-1:0] sample_o
);
  logic [WLONG-1:0] w;
  logic             top;
  int unsigned      nbits;

  always_comb begin
    nbits = short_i ? WSHORT : WLONG;
    for (int unsigned j = 0; j < WLONG; j++)
      w[j] = sel_odd_i ? hist_i[j + 1] : hist_i[j];
    top = (short_i ? w[WSHORT-1] : w[WLONG-1]) ^ offs_i;
    // recode the top bit and replicate it upward
    for (int unsigned j = 0; j < WLONG; j++)
      if (j + 1 >= nbits) w[j] = top;
    sample_o = w;
  end
endmodule

// File: rtl/adc_ddr_deser.sv
module adc_ddr_deser
  import adc_deser_pkg::*;
#(
  parameter int unsigned LANES  = LANE_COUNT,
  parameter int unsigned WLONG  = WORD_LONG,
  parameter int unsigned WSHORT = WORD_SHORT,
  parameter int unsigned RUN    = LOCK_RUN
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   short_mode_i,
  input  logic                   offset_bin_i,
  input  logic [LANES-1:0]       lane_rise_i,
  input  logic [LANES-1:0]       lane_fall_i,
  input  logic                   frame_rise_i,
  input  logic                   frame_fall_i,
  output logic [LANES*WLONG-1:0] samples_o,
  output logic                   valid_o,
  output logic                   locked_o
);
  localparam int unsigned DEPTH = WLONG + 1;

  logic [DEPTH-1:0]       frm_hist;
  logic                   take, sel_odd, short_q;
  logic [LANES*WLONG-1:0] samples_new, samples_d, samples_q;
  logic                   valid_q;
  code_sel_e              code_sel;

  assign code_sel = code_sel_e'(offset_bin_i);

  adc_ddr_shift #(.DEPTH(DEPTH)) u_frm_shift (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise_i (frame_rise_i),
    .fall_i (frame_fall_i),
    .hist_o (frm_hist)
  );

  adc_frame_lock #(
    .WLONG (WLONG), .WSHORT(WSHORT), .DEPTH(DEPTH), .RUN(RUN)
  ) u_lock (
    .clk        (clk),
    .rst_n      (rst_n),
    .short_i    (short_mode_i),
    .frm_hist_i (frm_hist),
    .take_o     (take),
    .sel_odd_o  (sel_odd),
    .locked_o   (locked_o),
    .short_q_o  (short_q)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DEPTH-1:0] hist;
    logic [WLONG-1:0] word;

    adc_ddr_shift #(.DEPTH(DEPTH)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .rise_i (lane_rise_i[g]),
      .fall_i (lane_fall_i[g]),
      .hist_o (hist)
    );

    adc_lane_fmt #(.WLONG(WLONG), .WSHORT(WSHORT), .DEPTH(DEPTH)) u_fmt (
      .hist_i    (hist),
      .sel_odd_i (sel_odd),
      .short_i   (short_q),
      .offs_i    (code_sel == CODE_OFFSET),
      .sample_o  (word)
    );

    assign samples_new[g*WLONG +: WLONG] = word;
  end

  always_comb begin
    samples_d = samples_q;
    if (take) samples_d = samples_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      samples_q <= '0;
      valid_q   <= 1'b0;
    end else begin
      samples_q <= samples_d;
      valid_q   <= take;
    end
  end

  assign samples_o = samples_q;
  assign valid_o   = valid_q;
endmodule

// File: rtl/adc_ddr_deser_chk.sv
module adc_ddr_deser_chk #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned WLONG  = 14,
  parameter int unsigned WSHORT = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   short_mode_i,
  input logic [LANES*WLONG-1:0] samples_o,
  input logic                   valid_o,
  input logic                   locked_o
);
  logic prev_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_mode <= 1'b0;
    else        prev_mode <= short_mode_i;
  end

  function automatic logic ext_ok(input logic [LANES*WLONG-1:0] s);
    logic ok;
    ok = 1'b1;
    for (int unsigned l = 0; l < LANES; l++)
      for (int unsigned b = WSHORT; b < WLONG; b++)
        if (s[l*WLONG + b] != s[l*WLONG + WSHORT - 1]) ok = 1'b0;
    return ok;
  endfunction

  a_r5_valid_needs_lock: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> locked_o);

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  a_r5_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(samples_o));

  a_r3_lock_with_word: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked_o) |-> valid_o);

  a_r8_mode_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (short_mode_i != prev_mode) |=> (!locked_o && !valid_o));

  a_r6_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && prev_mode) |-> ext_ok(samples_o));
endmodule

bind adc_ddr_deser adc_ddr_deser_chk #(
  .LANES(LANES), .WLONG(WLONG), .WSHORT(WSHORT)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .short_mode_i (short_mode_i),
  .samples_o    (samples_o),
  .valid_o      (valid_o),
  .locked_o     (locked_o)
);

// File: tb/test_adc_ddr_deser.sv
module test_adc_ddr_deser;
  localparam int LANES = 8;
  localparam int WL    = 14;
  localparam int RUN   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic short_mode = 1'b0, offset_bin = 1'b0;
  logic [LANES-1:0] lane_rise = '0, lane_fall = '0;
  logic frame_rise = 1'b0, frame_fall = 1'b0;
  logic [LANES*WL-1:0] samples;
  logic valid, locked;

  always #2 clk = ~clk;

  adc_ddr_deser i_adc_ddr_deser (
    .clk(clk), .rst_n(rst_n), .short_mode_i(short_mode), .offset_bin_i(offset_bin),
    .lane_rise_i(lane_rise), .lane_fall_i(lane_fall),
    .frame_rise_i(frame_rise), .frame_fall_i(frame_fall),
    .samples_o(samples), .valid_o(valid), .locked_o(locked)
  );

  int checks = 0, errors = 0;

  // stimulus: one entry per bit time, bit LANES is the frame lane
  logic [LANES:0] gq[$];
  int gen_n = 14, frame_idx = 0;
  bit drv_short = 0, drv_fmt = 0;

  // reference model state
  logic [LANES:0] mq[$];
  int  m_cnt = 0, m_gap = 0, m_off = 0;
  bit  m_short = 0, m_valid = 0, m_locked = 0;
  logic [WL-1:0] m_samp[LANES];
  string m_tag = "R2";
  int vcount = 0;
  bit saw_drop = 0;

  task automatic chk(bit ok, string tag, string what, logic [LANES*WL-1:0] act, logic [LANES*WL-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic int sample_val(int l, int idx, int n);
    int v;
    v = 100 + l * 1733 + idx * (41 + l * 97);
    return v & ((1 << n) - 1);
  endfunction

  task automatic push_frame();
    for (int b = 0; b < gen_n; b++) begin
      logic [LANES:0] e;
      for (int l = 0; l < LANES; l++) begin
        int v;
        v = sample_val(l, frame_idx, gen_n);
        e[l] = v[gen_n-1-b];
      end
      e[LANES] = (b < gen_n / 2);
      gq.push_back(e);
    end
    frame_idx++;
  endtask

  function automatic bit model_hit(int o, int n);
    for (int j = 0; j < n; j++) begin
      logic [LANES:0] e;
      e = mq[mq.size()-1-o-j];
      if (e[LANES] != (j >= n / 2)) return 0;
    end
    return 1;
  endfunction

  function automatic logic [WL-1:0] model_word(int l, int o, int n, bit fmt);
    logic [WL-1:0] w;
    logic top;
    w = '0;
    for (int j = 0; j < n; j++) begin
      logic [LANES:0] e;
      e = mq[mq.size()-1-o-j];
      w[j] = e[l];
    end
    top = w[n-1] ^ fmt;
    for (int j = 0; j < WL; j++) if (j >= n - 1) w[j] = top;
    return w;
  endfunction

  task automatic step();
    logic [LANES:0] a, b;
    logic [LANES*WL-1:0] expv;
    int n, cnt;
    bit h0, h1, hit, chg, ontime;
    int ho;
    @(negedge clk);
    while (gq.size() < 2) push_frame();
    a = gq.pop_front();
    b = gq.pop_front();
    lane_rise = a[LANES-1:0]; lane_fall = b[LANES-1:0];
    frame_rise = a[LANES];    frame_fall = b[LANES];
    short_mode = drv_short;   offset_bin = drv_fmt;
    // expected outputs after the coming edge
    n = m_short ? 12 : 14;
    h0 = model_hit(0, n);
    h1 = model_hit(1, n);
    hit = h0 | h1;
    ho = h0 ? 0 : 1;
    chg = (drv_short != m_short);
    ontime = (m_cnt > 0) && (m_gap == n / 2 - 1);
    cnt = m_cnt;
    if (chg) begin
      cnt = 0; m_gap = 0;
    end else if (hit) begin
      if (ontime && ho == m_off) cnt = (m_cnt < RUN) ? m_cnt + 1 : RUN;
      else cnt = 1;
      m_gap = 0; m_off = ho;
    end else begin
      if (ontime) cnt = 0;
      m_gap = m_gap + 1;
    end
    m_cnt = cnt;
    m_valid = hit && !chg && (cnt == RUN);
    m_locked = (cnt == RUN);
    if (m_valid) begin
      for (int l = 0; l < LANES; l++) m_samp[l] = model_word(l, ho, n, drv_fmt);
      m_tag = m_short ? "R6" : (drv_fmt ? "R7" : "R2");
    end
    m_short = drv_short;
    @(posedge clk);
    #1;
    for (int l = 0; l < LANES; l++) expv[l*WL +: WL] = m_samp[l];
    chk(valid == m_valid, "R5", "valid", {111'b0, valid}, {111'b0, m_valid});
    chk(locked == m_locked, "R3", "locked", {111'b0, locked}, {111'b0, m_locked});
    chk(samples == expv, m_tag, "samples", samples, expv);
    if (valid) vcount++;
    if (!locked) saw_drop = 1;
    mq.push_back(a);
    mq.push_back(b);
    while (mq.size() > 16) void'(mq.pop_front());
  endtask

  task automatic run(int k);
    for (int i = 0; i < k; i++) step();
  endtask

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) mq.push_back('0);
    for (int l = 0; l < LANES; l++) m_samp[l] = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk(valid == 0, "R1", "valid in reset", {111'b0, valid}, '0);
    chk(locked == 0, "R1", "locked in reset", {111'b0, locked}, '0);
    chk(samples == '0, "R1", "samples in reset", samples, '0);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: 14-bit two's complement ramps
    vcount = 0;
    run(70);
    chk(vcount >= 6, "R2", "words released", vcount, 6);
    chk(locked == 1, "R3", "locked after 14-bit frames", {111'b0, locked}, 1);

    // R7: offset binary
    drv_fmt = 1; vcount = 0;
    run(40);
    chk(vcount >= 4, "R7", "offset words released", vcount, 4);

    // R4: one-bit slip on every lane
    while (gq.size() == 0) push_frame();
    gq.push_front(gq[0]);
    saw_drop = 0;
    run(45);
    chk(saw_drop == 1, "R4", "lock lost after slip", {111'b0, saw_drop}, 1);
    chk(locked == 1, "R4", "lock regained after slip", {111'b0, locked}, 1);

    // R8 and R6: switch to 12-bit words
    gq.delete(); gen_n = 12; drv_short = 1; drv_fmt = 0;
    step();
    chk(locked == 0, "R8", "lock cleared on mode change", {111'b0, locked}, 0);
    vcount = 0;
    run(60);
    chk(vcount >= 5, "R6", "12-bit words released", vcount, 5);
    chk(locked == 1, "R8", "relock in 12-bit mode", {111'b0, locked}, 1);

    // R6 and R7 together
    drv_fmt = 1;
    run(40);

    // R8: back to 14-bit
    gq.delete(); gen_n = 14; drv_short = 0; drv_fmt = 0;
    step();
    chk(locked == 0, "R8", "lock cleared on return", {111'b0, locked}, 0);
    run(50);
    chk(locked == 1, "R3", "relock in 14-bit mode", {111'b0, locked}, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule